// File: doc/BRIEF.md
# Second-Level Cache Set Replacement with Selectable Insertion Depth

This block tracks the tags, valid bits and recency order of every set in a set-associative second-level cache. It decides the replacement victim of each allocating fill. Each fill also carries a priority from the level above, and the block uses it to choose where the new line enters the recency stack. A normal fill enters at the most-recently-used end. A low-priority fill enters at the least-recently-used end, so it is the next line to go unless a reference reaches it first. A fill marked for dropping is discarded entirely.

Each accepted request produces one registered response. The response reports hit or miss, the way involved, and whether a valid line was displaced; when one was, it also gives that line's tag. Lookups that hit move the line to the most-recently-used end. Lookups that miss allocate nothing. Line data, banking and access latency are handled elsewhere.

Top module: `l2_recency_insert`

## Requirements
- R1: After reset every way of every set is invalid and `rspValid` is low, so any lookup misses until a fill allocates.
- R2: A lookup (op 0) reports a hit and the matching way when a valid way of the addressed set holds the tag. Otherwise it reports a miss and changes no state.
- R3: A lookup hit moves the line to the most-recently-used position, and this applies equally to a line that entered at low priority.
- R4: A normal fill (op 1) of an absent tag writes the tag into the victim way and places it at the most-recently-used position.
- R5: A low-priority fill (op 2) of an absent tag writes the tag into the victim way at the least-recently-used position, so the next allocation in that set evicts it unless a hit promotes it first.
- R6: The victim is the lowest-indexed invalid way, or the least-recently-used way when all ways are valid. `rspEvict` is high, with the displaced tag on `rspEvictTag`, only when a valid line was displaced.
- R7: A fill (op 1 or 2) whose tag is already present reports a hit on that way, evicts nothing, and moves the line to most-recently-used.
- R8: A drop-marked fill (op 3) produces no response and changes no tag, valid bit or recency state.
- R9: The response to a request accepted at a clock edge appears on the outputs from that edge until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 0 lookup, 1 normal fill, 2 low-priority fill, 3 drop-marked fill |
| reqSet | input | SET_W | Set index |
| reqTag | input | TAG_W | Tag of the requested line |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspHit | output | 1 | Tag was found in the set |
| rspEvict | output | 1 | A valid line was displaced |
| rspEvictTag | output | TAG_W | Tag of the displaced line |
| rspWay | output | WAY_W | Way that hit or was allocated |

## Verification
Requests update state and the response registers at the same edge. Every result is therefore due on the outputs one edge after the request is accepted. The bench drives at the falling edge and samples at the following falling edge, before it drives the next request. Back-to-back requests to the same set exercise the forwarding of freshly written recency.

A bench model of the set state, built from the requirements, supplies the expected hit, way and eviction for every response. Drops and missed lookups are judged through later lookups and victims on the same set.

// File: rtl/l2ins_pkg.sv
package l2ins_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP   = 2'd0,
    OP_FILL     = 2'd1,
    OP_FILL_LOW = 2'd2,
    OP_DROP     = 2'd3
  } opKind_e;

  typedef struct packed {
    logic respond;   // request produces a response
    logic hit;       // tag found
    logic touch;     // recency row is rewritten
    logic alloc;     // tag/valid written into selected way
    logic evict;     // allocation displaces a valid line
    logic toLru;     // insert at the least-recently-used end
  } ctrlStrobe_t;
endpackage

// File: rtl/l2ins_ctrl.sv
module l2ins_ctrl
  import l2ins_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int TAG_W = 12,
  parameter int WAY_W = $clog2(WAYS),
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic [1:0]                      reqOp,
  input  logic [TAG_W-1:0]                reqTag,
  input  logic [WAYS-1:0][TAG_W-1:0]      rowTag,
  input  logic [WAYS-1:0]                 rowValid,
  input  logic [WAYS-1:0][AGE_W-1:0]      rowAge,
  output ctrlStrobe_t                     strobe,
  output logic [WAY_W-1:0]                selWay
);
  localparam logic [AGE_W-1:0] LRU_AGE = AGE_W'(WAYS - 1);

  opKind_e          op;
  logic [WAYS-1:0]  hitVec;
  logic             anyHit;
  logic             isFill;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] victimWay;

  assign op = opKind_e'(reqOp);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = rowValid[w] && (rowTag[w] == reqTag);
  end

  assign anyHit = |hitVec;
  assign isFill = (op == OP_FILL) || (op == OP_FILL_LOW);

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  always_comb begin
    victimWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rowAge[w] == LRU_AGE) victimWay = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rowValid[w]) victimWay = WAY_W'(w);
    end
  end

  assign selWay = anyHit ? hitWay : victimWay;

  always_comb begin
    strobe         = '0;
    strobe.respond = reqValid && (op != OP_DROP);
    strobe.hit     = anyHit;
    strobe.touch   = strobe.respond && (anyHit || isFill);
    strobe.alloc   = strobe.respond && isFill && !anyHit;
    strobe.evict   = strobe.alloc && rowValid[victimWay];
    strobe.toLru   = strobe.alloc && (op == OP_FILL_LOW);
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot0(hitVec));

  // R6
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.alloc && !(&rowValid)) |-> !rowValid[selWay]);

  // R8
  drop_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && op == OP_DROP) |-> (!strobe.touch && !strobe.alloc));
endmodule

// File: rtl/l2ins_dp.sv
module l2ins_dp
  import l2ins_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int TAG_W = 12,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS),
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SET_W-1:0]            reqSet,
  input  logic [TAG_W-1:0]            reqTag,
  input  ctrlStrobe_t                 strobe,
  input  logic [WAY_W-1:0]            selWay,
  output logic [WAYS-1:0][TAG_W-1:0]  rowTag,
  output logic [WAYS-1:0]             rowValid,
  output logic [WAYS-1:0][AGE_W-1:0]  rowAge,
  output logic                        rspValid,
  output logic                        rspHit,
  output logic                        rspEvict,
  output logic [TAG_W-1:0]            rspEvictTag,
  output logic [WAY_W-1:0]            rspWay
);
  localparam logic [AGE_W-1:0] LRU_AGE = AGE_W'(WAYS - 1);

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tagMem;
  logic [SETS-1:0][WAYS-1:0]            validMem;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] ageMem;
  logic [WAYS-1:0][AGE_W-1:0]           newAge;
  logic [AGE_W-1:0]                     selAge;

  assign rowTag   = tagMem[reqSet];
  assign rowValid = validMem[reqSet];
  assign rowAge   = ageMem[reqSet];
  assign selAge   = rowAge[selWay];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      newAge[w] = rowAge[w];
      if (strobe.toLru) begin
        if (WAY_W'(w) == selWay)   newAge[w] = LRU_AGE;
        else if (rowAge[w] > selAge) newAge[w] = rowAge[w] - AGE_W'(1);
      end else begin
        if (WAY_W'(w) == selWay)   newAge[w] = '0;
        else if (rowAge[w] < selAge) newAge[w] = rowAge[w] + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w]   <= '0;
          validMem[s][w] <= 1'b0;
          ageMem[s][w]   <= AGE_W'(w);
        end
      end
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspEvict    <= 1'b0;
      rspEvictTag <= '0;
      rspWay      <= '0;
    end else begin
      if (strobe.touch) ageMem[reqSet] <= newAge;
      if (strobe.alloc) begin
        tagMem[reqSet][selWay]   <= reqTag;
        validMem[reqSet][selWay] <= 1'b1;
      end
      rspValid    <= strobe.respond;
      rspHit      <= strobe.hit;
      rspEvict    <= strobe.evict;
      rspEvictTag <= rowTag[selWay];
      rspWay      <= selWay;
    end
  end

  // R3 R4 R7
  promote_mru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touch && !strobe.toLru) |=> ageMem[$past(reqSet)][$past(selWay)] == '0);

  // R5
  low_at_lru_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toLru |=> ageMem[$past(reqSet)][$past(selWay)] == LRU_AGE);

  // R6
  evict_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspEvict |-> (rspValid && !rspHit));
endmodule

// File: rtl/l2_recency_insert.sv
module l2_recency_insert
  import l2ins_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int TAG_W = 12,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [SET_W-1:0] reqSet,
  input  logic [TAG_W-1:0] reqTag,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspEvict,
  output logic [TAG_W-1:0] rspEvictTag,
  output logic [WAY_W-1:0] rspWay
);
  localparam int AGE_W = $clog2(WAYS);

  ctrlStrobe_t                strobe;
  logic [WAY_W-1:0]           selWay;
  logic [WAYS-1:0][TAG_W-1:0] rowTag;
  logic [WAYS-1:0]            rowValid;
  logic [WAYS-1:0][AGE_W-1:0] rowAge;

  l2ins_ctrl #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqTag(reqTag),
    .rowTag(rowTag), .rowValid(rowValid), .rowAge(rowAge),
    .strobe(strobe), .selWay(selWay)
  );

  l2ins_dp #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W),
             .AGE_W(AGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .reqTag(reqTag),
    .strobe(strobe), .selWay(selWay),
    .rowTag(rowTag), .rowValid(rowValid), .rowAge(rowAge),
    .rspValid(rspValid), .rspHit(rspHit), .rspEvict(rspEvict),
    .rspEvictTag(rspEvictTag), .rspWay(rspWay)
  );
endmodule

// File: tb/l2_recency_insert_bench.sv
`timescale 1ns/1ps
module l2_recency_insert_bench;
  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int TAG_W = 4;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [1:0]       reqOp = '0;
  logic [SET_W-1:0] reqSet = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic             rspValid, rspHit, rspEvict;
  logic [TAG_W-1:0] rspEvictTag;
  logic [WAY_W-1:0] rspWay;

  int checks = 0;
  int errors = 0;

  int mTag [SETS][WAYS];
  bit mVal [SETS][WAYS];
  int mAge [SETS][WAYS];

  always #2.5 clk = ~clk;

  l2_recency_insert #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_l2_recency_insert (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqSet(reqSet),
    .reqTag(reqTag), .rspValid(rspValid), .rspHit(rspHit), .rspEvict(rspEvict),
    .rspEvictTag(rspEvictTag), .rspWay(rspWay)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic promote(int s, int w);
    for (int k = 0; k < WAYS; k++) if (k != w && mAge[s][k] < mAge[s][w]) mAge[s][k]++;
    mAge[s][w] = 0;
  endtask

  task automatic demote(int s, int w);
    for (int k = 0; k < WAYS; k++) if (k != w && mAge[s][k] > mAge[s][w]) mAge[s][k]--;
    mAge[s][w] = WAYS - 1;
  endtask

  // Called at a falling edge; returns at the falling edge where the response is due.
  task automatic doOp(int op, int s, int t, string force_req);
    int hw = -1, vw = -1;
    bit expEv = 0;
    int evTag = 0, expWay = 0;
    string req;
    for (int k = 0; k < WAYS; k++) if (mVal[s][k] && mTag[s][k] == t) hw = k;
    if (op == 3) req = "R8";
    else if (hw >= 0) req = (op == 0) ? "R3" : "R7";
    else if (op == 0) req = "R2";
    else req = (op == 2) ? "R5" : "R4";
    if (force_req != "") req = force_req;
    if (op != 3) begin
      if (hw >= 0) begin
        promote(s, hw); expWay = hw;
      end else if (op != 0) begin
        for (int k = 0; k < WAYS; k++) if (mAge[s][k] == WAYS - 1) vw = k;
        for (int k = WAYS - 1; k >= 0; k--) if (!mVal[s][k]) vw = k;
        expEv = mVal[s][vw]; evTag = mTag[s][vw]; expWay = vw;
        mTag[s][vw] = t; mVal[s][vw] = 1;
        if (op == 2) demote(s, vw); else promote(s, vw);
      end
    end
    reqValid = 1'b1; reqOp = 2'(op); reqSet = SET_W'(s); reqTag = TAG_W'(t);
    @(negedge clk);
    reqValid = 1'b0;
    // R9: response due one edge after acceptance
    check((op == 3) ? "R8" : "R9", "rspValid", int'(rspValid), (op == 3) ? 0 : 1);
    if (op != 3) begin
      check(req, "rspHit", int'(rspHit), (hw >= 0) ? 1 : 0);
      check((op != 0 && hw < 0) ? "R6" : req, "rspEvict", int'(rspEvict), int'(expEv));
      if (expEv) check("R6", "rspEvictTag", int'(rspEvictTag), evTag);
      if (hw >= 0 || op != 0) check(req, "rspWay", int'(rspWay), expWay);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mTag[s][w] = 0; mVal[s][w] = 0; mAge[s][w] = w;
      end
    repeat (3) @(negedge clk);
    // R1: no response in reset state
    check("R1", "rspValid in reset", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "rspValid after reset", int'(rspValid), 0);
    // R1: every set empty, including tag 0 that matches the cleared tag storage
    for (int s = 0; s < SETS; s++) doOp(0, s, 0, "R1");
    for (int s = 0; s < SETS; s++) doOp(0, s, 5, "R1");

    // R5: low-priority line is the next victim
    for (int t = 1; t <= WAYS; t++) doOp(1, 1, t, "");
    doOp(2, 1, 9, "R5");       // evicts tag 1, enters at LRU
    doOp(1, 1, 10, "R5");      // evicts tag 9
    // R3: hit on a low-priority line promotes it
    doOp(2, 1, 11, "");
    doOp(0, 1, 11, "R3");
    doOp(1, 1, 12, "R3");      // must not evict 11
    doOp(0, 1, 11, "R3");
    // R7: fill of a present tag
    doOp(2, 1, 11, "R7");
    doOp(1, 1, 12, "R7");
    // R8: drop of a resident-candidate tag leaves the set untouched
    doOp(3, 2, 7, "R8");
    doOp(0, 2, 7, "R8");
    for (int t = 1; t <= WAYS; t++) doOp(1, 2, t, "");
    doOp(3, 2, 13, "R8");
    doOp(1, 2, 14, "R8");      // victim still tag 1

    // near-exhaustive mixed sweep over the small configuration
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom;
      doOp(r[1:0], int'(r[4:2]) % SETS, int'(r[9:6]) % 6 + (r[10] ? 0 : 8), "");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule